// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Flow Control

This block sends bytes on an asynchronous serial line. Each frame is a low start bit, eight data bits least significant first, and a high stop bit. The line rests high between frames. A CPU-side write strobe loads a one-entry holding register. As soon as the shifter is free, the byte moves from the holding register into the shifter. The block then pulses a transmit interrupt so the CPU can supply the next byte. Bit timing comes from an external enable pulse, `tick`. Each pulse marks one falling edge of the divided transmit clock, and each bit lasts `TICKS_PER_BIT` pulses.

With `hs_en` set, the clear-to-send input `cts_hold` acts as a frame-level brake. A high level stops the next frame from starting but never cuts one short. The input passes through a two-flop synchronizer and is examined only when a loaded frame is waiting to go. While sending is held, the handoff and its interrupt still take place, so one byte can wait in the shifter and a second in the holding register. When the synchronized input returns low, the waiting frame starts on the next `tick`.

Top module: `uart_cts_tx`

## Requirements
- R1: While `rst_n` is low and after its release, `txd` is 1, `buf_full` is 0, `tx_irq` is 0 and `ovr_err` is 0, until the first write.
- R2: Each frame drives `txd` low for one bit time, then data bits 0 to 7 in that order, then a high stop bit. One bit time is `TICKS_PER_BIT` `tick` pulses. `txd` changes only on a clock edge where `tick` is high.
- R3: A write while `buf_full` is 0 sets `buf_full` on the next edge. The move into an idle shifter clears `buf_full` and pulses `tx_irq` high for exactly one cycle, on the second edge after the write.
- R4: A write while `buf_full` is 1 is dropped: no frame carries that byte. It sets `ovr_err`, which stays set until reset.
- R5: With `hs_en` at 0, the level of `cts_hold` has no effect, and frames go out while it is held high.
- R6: With `hs_en` at 1 and `cts_hold` high, no frame starts. The holding register still hands its byte to the shifter and pulses `tx_irq`. A byte written after that stays pending with `buf_full` at 1.
- R7: If `cts_hold` rises while a frame is being sent, that frame completes with all ten bits. The following frame waits until `cts_hold` is low again.
- R8: A start bit always begins at the clock edge where `tick` is high. After the synchronized `cts_hold` goes low, the waiting frame begins on the first such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable marking a falling edge of the transmit bit clock |
| hs_en | input | 1 | 1 enables clear-to-send flow control |
| cts_hold | input | 1 | Clear-to-send, high requests that sending pause (asynchronous) |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| txd | output | 1 | Serial output, idles high |
| tx_irq | output | 1 | One-cycle pulse when a byte moves into the shifter |
| buf_full | output | 1 | Holding register occupied |
| ovr_err | output | 1 | Sticky flag: a write was dropped because the register was full |

## Verification
Bytes A5, 3C, F0, 0F, 55 and C3 are sent. Alternating and nibble-split patterns expose a reversed bit order or an off-by-one bit count that a uniform byte would hide. A back-to-back pair with flow control off shows that the pending byte follows without being lost, and a third write in that window shows it is dropped. A hold applied before any byte arrives separates "handoff and interrupt go on" from "line stays idle". A hold raised mid-frame separates completion of the current frame from suppression of the next one. Every observed start bit is checked against the `tick` of its edge.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_HOLD = 2'd1,
    TX_SEND = 2'd2
  } tx_state_t;
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/tx_holding.sv
module tx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              ovr_err
);
  logic              full_n, ovr_n, load;
  logic [DATA_W-1:0] data_n;

  always_comb begin
    load   = wr_en && !full;
    full_n = full;
    ovr_n  = ovr_err;
    data_n = data;
    if (take)  full_n = 1'b0;
    if (load) begin
      full_n = 1'b1;
      data_n = wr_data;
    end
    if (wr_en && full) ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      ovr_err <= 1'b0;
      data    <= '0;
    end else begin
      full    <= full_n;
      ovr_err <= ovr_n;
      if (load) data <= data_n;
    end
  end
endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hs_en,
  input  logic              hold_sync,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  output logic              take,
  output logic              txd,
  output logic              tx_irq,
  output tx_state_t         state
);
  localparam int TCNT_W   = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int LAST_BIT = DATA_W + 1;
  localparam int BIT_W    = $clog2(LAST_BIT + 1);
  localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(TICKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(LAST_BIT);

  tx_state_t         state_n;
  logic [DATA_W:0]   frame_q, frame_n;
  logic [TCNT_W-1:0] tcnt_q, tcnt_n;
  logic [BIT_W-1:0]  bidx_q, bidx_n;
  logic              txd_n, irq_n, go;

  assign go = tick && (!hs_en || !hold_sync);

  always_comb begin
    state_n = state;
    frame_n = frame_q;
    tcnt_n  = tcnt_q;
    bidx_n  = bidx_q;
    txd_n   = txd;
    take    = 1'b0;
    case (state)
      TX_IDLE: begin
        if (buf_full) begin
          take    = 1'b1;
          frame_n = {1'b1, buf_data};
          state_n = TX_HOLD;
        end
      end
      TX_HOLD: begin
        if (go) begin
          state_n = TX_SEND;
          txd_n   = 1'b0;
          tcnt_n  = '0;
          bidx_n  = '0;
        end
      end
      TX_SEND: begin
        if (tick) begin
          if (tcnt_q == TCNT_LAST) begin
            tcnt_n = '0;
            if (bidx_q == BIT_LAST) begin
              state_n = TX_IDLE;
              txd_n   = 1'b1;
            end else begin
              bidx_n  = bidx_q + 1'b1;
              txd_n   = frame_q[0];
              frame_n = {1'b1, frame_q[DATA_W:1]};
            end
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
      end
      default: state_n = TX_IDLE;
    endcase
    irq_n = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      frame_q <= '1;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      txd     <= 1'b1;
      tx_irq  <= 1'b0;
    end else begin
      state   <= state_n;
      frame_q <= frame_n;
      tcnt_q  <= tcnt_n;
      bidx_q  <= bidx_n;
      txd     <= txd_n;
      tx_irq  <= irq_n;
    end
  end
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hs_en,
  input  logic              cts_hold,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_irq,
  output logic              buf_full,
  output logic              ovr_err
);
  logic              hold_sync, take;
  logic [DATA_W-1:0] buf_data;
  tx_state_t         tx_state;

  cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cts_hold),
    .sync_out (hold_sync)
  );

  tx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (buf_full),
    .data    (buf_data),
    .ovr_err (ovr_err)
  );

  tx_framer #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hs_en     (hs_en),
    .hold_sync (hold_sync),
    .buf_full  (buf_full),
    .buf_data  (buf_data),
    .take      (take),
    .txd       (txd),
    .tx_irq    (tx_irq),
    .state     (tx_state)
  );
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk
  import uart_tx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tick,
  input logic      wr_en,
  input logic      hs_en,
  input logic      hold_sync,
  input logic      txd,
  input logic      tx_irq,
  input logic      buf_full,
  input logic      ovr_err,
  input tx_state_t st
);
  p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  p_irq_frees_buf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> !buf_full);

  p_txd_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tick));

  p_full_write_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && buf_full) |=> ovr_err);

  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |=> ovr_err);

  p_hold_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_HOLD && hs_en && hold_sync) |=> txd);

  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_IDLE) |-> txd);
endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_en     (wr_en),
  .hs_en     (hs_en),
  .hold_sync (hold_sync),
  .txd       (txd),
  .tx_irq    (tx_irq),
  .buf_full  (buf_full),
  .ovr_err   (ovr_err),
  .st        (tx_state)
);

// File: tb/sim_uart_cts_tx.sv
`timescale 1ns/1ps
module sim_uart_cts_tx;
  localparam int TPB     = 16;
  localparam int TDIV    = 2;
  localparam int BIT_CYC = TPB * TDIV;

  logic       clk, rst_n, tick, hs_en, cts_hold, wr_en;
  logic [7:0] wr_data;
  logic       txd, tx_irq, buf_full, ovr_err;
  logic       tick_seen;
  logic       blocked;
  int         checks, fails, irq_cnt, tdiv_cnt;
  logic [7:0] exp_q[$];

  uart_cts_tx #(.DATA_W(8), .TICKS_PER_BIT(TPB)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hs_en(hs_en),
    .cts_hold(cts_hold), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .tx_irq(tx_irq), .buf_full(buf_full), .ovr_err(ovr_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tdiv_cnt == TDIV - 1) begin
      tdiv_cnt = 0;
      tick = 1'b1;
    end else begin
      tdiv_cnt = tdiv_cnt + 1;
      tick = 1'b0;
    end
  end

  always @(posedge clk) begin
    tick_seen <= tick;
    if (rst_n && tx_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic write_byte(input logic [7:0] b, input bit accept);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = b;
    if (accept) exp_q.push_back(b);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) step(1);
    step(BIT_CYC);
  endtask

  // monitor: decodes frames from txd and compares against the scoreboard
  initial begin
    logic [7:0] got;
    logic       stop_b;
    forever begin
      step(1);
      if (rst_n && txd == 1'b0) begin
        check(tick_seen == 1'b1, "R8", "start bit not on tick edge", tick_seen, 1);
        check(!blocked, "R6", "frame started while held", blocked, 0);
        step(BIT_CYC / 2 - 1);
        check(txd == 1'b0, "R2", "start bit level", txd, 0);
        for (int i = 0; i < 8; i++) begin
          step(BIT_CYC);
          got[i] = txd;
        end
        step(BIT_CYC);
        stop_b = txd;
        check(stop_b == 1'b1, "R2", "stop bit level", stop_b, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected frame", got, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(got == e, "R2", "frame data", got, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    checks = 0; fails = 0; irq_cnt = 0; tdiv_cnt = 0;
    tick = 0; rst_n = 0; hs_en = 0; cts_hold = 0; wr_en = 0; wr_data = 0;
    blocked = 1'b0;
    step(5);
    check(txd == 1'b1, "R1", "txd in reset", txd, 1);
    check(buf_full == 1'b0 && tx_irq == 1'b0 && ovr_err == 1'b0, "R1",
          "flags in reset", {buf_full, tx_irq, ovr_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(4);
    check(txd == 1'b1 && buf_full == 1'b0 && ovr_err == 1'b0, "R1",
          "state after release", {txd, buf_full, ovr_err}, 4);

    // R5 and R3/R4: handshake off, CTS held high, back-to-back bytes
    hs_en = 1'b0; cts_hold = 1'b1;
    write_byte(8'hA5, 1'b1);
    check(buf_full == 1'b1, "R3", "full after write", buf_full, 1);
    step(1);
    check(tx_irq == 1'b1 && buf_full == 1'b0, "R3", "handoff irq",
          {tx_irq, buf_full}, 2);
    step(1);
    check(tx_irq == 1'b0, "R3", "irq one cycle", tx_irq, 0);
    write_byte(8'h3C, 1'b1);
    check(buf_full == 1'b1, "R3", "pending byte held", buf_full, 1);
    write_byte(8'h81, 1'b0);
    check(ovr_err == 1'b1, "R4", "overwrite flagged", ovr_err, 1);
    drain();
    check(ovr_err == 1'b1, "R4", "overwrite flag sticky", ovr_err, 1);
    check(irq_cnt == 2, "R5", "irq count with CTS ignored", irq_cnt, 2);

    // R6: handshake on, held before data arrives
    hs_en = 1'b1; cts_hold = 1'b1;
    step(4);
    blocked = 1'b1;
    base = irq_cnt;
    write_byte(8'hF0, 1'b1);
    step(2);
    check(irq_cnt == base + 1 && buf_full == 1'b0, "R6", "handoff while held",
          irq_cnt - base, 1);
    write_byte(8'h0F, 1'b1);
    step(5 * BIT_CYC);
    check(txd == 1'b1, "R6", "line idle while held", txd, 1);
    check(buf_full == 1'b1, "R6", "second byte pending", buf_full, 1);
    blocked = 1'b0;
    @(negedge clk); cts_hold = 1'b0;
    drain();
    check(irq_cnt == base + 2, "R6", "irq count after release", irq_cnt - base, 2);

    // R7: CTS rises mid-frame
    write_byte(8'h55, 1'b1);
    step(4);
    write_byte(8'hC3, 1'b1);
    while (txd == 1'b1) step(1);
    step(3 * BIT_CYC);
    @(negedge clk); cts_hold = 1'b1;
    step(4);
    blocked = 1'b1;
    while (exp_q.size() > 1) step(1);
    step(3 * BIT_CYC);
    check(exp_q.size() == 1, "R7", "next frame suppressed", exp_q.size(), 1);
    check(txd == 1'b1, "R7", "line idle after completed frame", txd, 1);
    blocked = 1'b0;
    @(negedge clk); cts_hold = 1'b0;
    drain();
    check(exp_q.size() == 0, "R8", "held frame sent after release", exp_q.size(), 0);
    check(ovr_err == 1'b1, "R4", "flag still set at end", ovr_err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule